// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit processor. In every cycle it looks at the major opcode and the function field of the fetched instruction, at the zero flag from the ALU subtract, and at the already synchronized reset and interrupt request. From these it drives every select and strobe the datapath needs: next-PC source, immediate extension mode, register write address and data sources, ALU function, ALU operand selects, memory write and register-file write.

Reset has the highest priority, then the interrupt request, then the instruction itself. An instruction outside the supported set does not execute. It is trapped: the next PC comes from the illegal-instruction vector and the return address PC+4 goes into register 27, the same way an interrupt saves it. Any control that a case below does not name is driven to 0, so every output is fully defined for every input.

Encodings. `pcSel`: 0 = PC+4, 1 = branch target, 2 = jump-immediate target, 3 = rs register value, 4 = reset vector, 5 = illegal-instruction vector, 6 = interrupt vector. `waSel`: 0 = rd, 1 = rt, 2 = constant 31, 3 = constant 27. `wdSel`: 0 = PC+4, 1 = ALU result, 2 = memory read data. `aSel`: 0 = rs data, 1 = shamt field, 2 = constant 16. `bSel`: 0 = rt data, 1 = extended immediate. `aluFn` is packed as {subtract, mode[1:0], shift, arith}. Its codes are: add 00001, sub 10001, and 00000, or 00100, xor 01000, nor 01100, shift-left 00010, shift-right-logical 01010, shift-right-arithmetic 01110, set-less-signed 10011, set-less-unsigned 10111.

Top module: `ctl_decoder`

## Requirements
- R1: While `rstSync` is 1, `pcSel`=4 and every other output is 0, whatever the other inputs are.
- R2: With `rstSync`=0 and `irqSync`=1, `pcSel`=6, `waSel`=3, `wdSel`=0, `regWr`=1 and every other output is 0.
- R3: With neither reset nor interrupt, an opcode/function pair outside the set of R4–R13 gives `pcSel`=5, `waSel`=3, `wdSel`=0, `regWr`=1 and every other output 0. Function codes 011000–011011 (multiply/divide) are in this unsupported set.
- R4: Opcode 000000 with function 100000/100001 (add), 100010/100011 (sub), 100100 (and), 100101 (or), 100110 (xor) or 100111 (nor) gives the matching `aluFn`, with `waSel`=0, `wdSel`=1 and `regWr`=1.
- R5: Opcode 000000 with a shift function gives `waSel`=0, `wdSel`=1 and `regWr`=1. Functions 000000/000010/000011 (sll/srl/sra) use `aSel`=1. Functions 000100/000110/000111 (the variable forms) use `aSel`=0 with the same shift `aluFn`.
- R6: Compares: function 101010/101011 under opcode 000000 write rd (`waSel`=0). Opcodes 001010/001011 write rt with `bSel`=1 and `sextEn`=1. Both forms use `wdSel`=1 and `regWr`=1; the signed form takes `aluFn` 10011 and the unsigned form 10111.
- R7: Opcodes 001000/001001 (add immediate) give `aluFn` add with `sextEn`=1. Opcodes 001100/001101/001110 (and/or/xor immediate) give the logic `aluFn` with `sextEn`=0. All of them use `bSel`=1, `waSel`=1, `wdSel`=1 and `regWr`=1.
- R8: Opcode 001111 (load upper) gives `aSel`=2, `aluFn` shift-left, `bSel`=1, `sextEn`=0, `waSel`=1, `wdSel`=1 and `regWr`=1.
- R9: Opcode 100011 (load) gives `aluFn` add, `bSel`=1, `sextEn`=1, `wdSel`=2, `waSel`=1 and `regWr`=1.
- R10: Opcode 101011 (store) gives `aluFn` add, `bSel`=1, `sextEn`=1, `memWr`=1 and `regWr`=0. `memWr` and `regWr` are never both 1.
- R11: Opcodes 000100 (equal) and 000101 (not equal) give `aluFn` sub, `bSel`=0, `sextEn`=1 and `regWr`=0. `pcSel` is 1 when `aluZero` is 1 for equal, or 0 for not equal; otherwise `pcSel` is 0.
- R12: Opcode 000010 gives `pcSel`=2 with no register write. Opcode 000011 gives `pcSel`=2, `waSel`=2, `wdSel`=0 and `regWr`=1.
- R13: Opcode 000000 with function 001000 gives `pcSel`=3 with no register write. Function 001001 gives `pcSel`=3, `waSel`=0, `wdSel`=0 and `regWr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| aluZero | input | 1 | ALU result-is-zero flag |
| rstSync | input | 1 | Synchronized reset request |
| irqSync | input | 1 | Synchronized interrupt request |
| pcSel | output | 3 | Next-PC source select |
| sextEn | output | 1 | 1 = sign-extend immediate, 0 = zero-extend |
| waSel | output | 2 | Register write address select |
| wdSel | output | 2 | Register write data select |
| aluFn | output | 5 | ALU function code |
| memWr | output | 1 | Data memory write strobe |
| regWr | output | 1 | Register file write enable |
| aSel | output | 2 | ALU A operand select |
| bSel | output | 1 | ALU B operand select |

## Verification
The decoder holds no state, so a wrong decode shows at the ports in the same cycle it is presented and never carries over to later inputs. The bench sweeps every opcode and function combination under both zero-flag values and all reset and interrupt settings. It compares the whole control vector against values worked out from the requirements. A misrouted class shows up as a wrong select code, a missing write enable shows up as `regWr`=0, and a broken priority shows up as the wrong vector code.

// File: rtl/ctl_decoder_pkg.sv
package ctl_decoder_pkg;

  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUFN_W = 5;
  localparam int PCSEL_W = 3;
  localparam int SEL2_W  = 2;

  // next-PC sources
  localparam logic [PCSEL_W-1:0] PC_SEQ     = 3'd0;
  localparam logic [PCSEL_W-1:0] PC_BRANCH  = 3'd1;
  localparam logic [PCSEL_W-1:0] PC_JIMM    = 3'd2;
  localparam logic [PCSEL_W-1:0] PC_JREG    = 3'd3;
  localparam logic [PCSEL_W-1:0] PC_RESET   = 3'd4;
  localparam logic [PCSEL_W-1:0] PC_ILLEGAL = 3'd5;
  localparam logic [PCSEL_W-1:0] PC_IRQ     = 3'd6;

  // write address sources
  localparam logic [SEL2_W-1:0] WA_RD  = 2'd0;
  localparam logic [SEL2_W-1:0] WA_RT  = 2'd1;
  localparam logic [SEL2_W-1:0] WA_R31 = 2'd2;
  localparam logic [SEL2_W-1:0] WA_R27 = 2'd3;

  // write data sources
  localparam logic [SEL2_W-1:0] WD_LINK = 2'd0;
  localparam logic [SEL2_W-1:0] WD_ALU  = 2'd1;
  localparam logic [SEL2_W-1:0] WD_MEM  = 2'd2;

  // A operand sources
  localparam logic [SEL2_W-1:0] A_RS      = 2'd0;
  localparam logic [SEL2_W-1:0] A_SHAMT   = 2'd1;
  localparam logic [SEL2_W-1:0] A_SIXTEEN = 2'd2;

  // ALU function codes {subtract, mode[1:0], shift, arith}
  localparam logic [ALUFN_W-1:0] FN_ADD  = 5'b00001;
  localparam logic [ALUFN_W-1:0] FN_SUB  = 5'b10001;
  localparam logic [ALUFN_W-1:0] FN_AND  = 5'b00000;
  localparam logic [ALUFN_W-1:0] FN_OR   = 5'b00100;
  localparam logic [ALUFN_W-1:0] FN_XOR  = 5'b01000;
  localparam logic [ALUFN_W-1:0] FN_NOR  = 5'b01100;
  localparam logic [ALUFN_W-1:0] FN_SLL  = 5'b00010;
  localparam logic [ALUFN_W-1:0] FN_SRL  = 5'b01010;
  localparam logic [ALUFN_W-1:0] FN_SRA  = 5'b01110;
  localparam logic [ALUFN_W-1:0] FN_SLT  = 5'b10011;
  localparam logic [ALUFN_W-1:0] FN_SLTU = 5'b10111;

  // major opcodes
  localparam logic [OP_W-1:0] OP_SPECIAL = 6'b000000;
  localparam logic [OP_W-1:0] OP_J       = 6'b000010;
  localparam logic [OP_W-1:0] OP_JAL     = 6'b000011;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'b000100;
  localparam logic [OP_W-1:0] OP_BNE     = 6'b000101;
  localparam logic [OP_W-1:0] OP_LUI     = 6'b001111;
  localparam logic [OP_W-1:0] OP_LW      = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW      = 6'b101011;
  localparam logic [2:0]      IMM_GROUP  = 3'b001;

  // function-field groups under OP_SPECIAL
  localparam logic [2:0] FG_SHIFT = 3'b000;
  localparam logic [2:0] FG_JREG  = 3'b001;
  localparam logic [2:0] FG_ALU   = 3'b100;
  localparam logic [2:0] FG_CMP   = 3'b101;

  typedef struct packed {
    logic                 legal;
    logic                 isBranch;
    logic                 brOnEq;
    logic                 isJumpImm;
    logic                 isJumpReg;
    logic                 regWrite;
    logic                 memWrite;
    logic [SEL2_W-1:0]    waSel;
    logic [SEL2_W-1:0]    wdSel;
    logic [SEL2_W-1:0]    aSel;
    logic                 bSel;
    logic                 sext;
    logic [ALUFN_W-1:0]   aluFn;
  } ctlStrobes_t;

endpackage

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
  import ctl_decoder_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output ctlStrobes_t     strobes
);

  ctlStrobes_t special;
  ctlStrobes_t immOp;

  // function-field decode for opcode 000000
  always_comb begin
    special       = '0;
    special.legal = 1'b1;
    special.waSel = WA_RD;
    special.wdSel = WD_ALU;
    unique case (funct[5:3])
      FG_ALU: begin
        special.regWrite = 1'b1;
        unique case (funct[2:0])
          3'b000, 3'b001: special.aluFn = FN_ADD;
          3'b010, 3'b011: special.aluFn = FN_SUB;
          3'b100:         special.aluFn = FN_AND;
          3'b101:         special.aluFn = FN_OR;
          3'b110:         special.aluFn = FN_XOR;
          default:        special.aluFn = FN_NOR;
        endcase
      end
      FG_SHIFT: begin
        special.regWrite = 1'b1;
        special.aSel     = funct[2] ? A_RS : A_SHAMT;
        unique case (funct[1:0])
          2'b00:   special.aluFn = FN_SLL;
          2'b10:   special.aluFn = FN_SRL;
          2'b11:   special.aluFn = FN_SRA;
          default: special.legal = 1'b0;
        endcase
      end
      FG_CMP: begin
        special.regWrite = 1'b1;
        special.aluFn    = funct[0] ? FN_SLTU : FN_SLT;
        special.legal    = (funct[2:1] == 2'b01);
      end
      FG_JREG: begin
        special.isJumpReg = 1'b1;
        special.wdSel     = WD_LINK;
        special.regWrite  = funct[0];
        special.legal     = (funct[2:1] == 2'b00);
      end
      default: special.legal = 1'b0;
    endcase
  end

  // ALU-with-immediate group, opcodes 001xxx
  always_comb begin
    immOp          = '0;
    immOp.legal    = 1'b1;
    immOp.regWrite = 1'b1;
    immOp.waSel    = WA_RT;
    immOp.wdSel    = WD_ALU;
    immOp.bSel     = 1'b1;
    unique case (opcode[2:0])
      3'b000, 3'b001: begin immOp.aluFn = FN_ADD;  immOp.sext = 1'b1; end
      3'b010:         begin immOp.aluFn = FN_SLT;  immOp.sext = 1'b1; end
      3'b011:         begin immOp.aluFn = FN_SLTU; immOp.sext = 1'b1; end
      3'b100:         immOp.aluFn = FN_AND;
      3'b101:         immOp.aluFn = FN_OR;
      3'b110:         immOp.aluFn = FN_XOR;
      default: begin
        immOp.aluFn = FN_SLL;
        immOp.aSel  = A_SIXTEEN;
      end
    endcase
  end

  // major opcode dispatch
  always_comb begin
    strobes       = '0;
    strobes.legal = 1'b1;
    if (opcode == OP_SPECIAL) begin
      strobes = special;
    end else if (opcode[5:3] == IMM_GROUP) begin
      strobes = immOp;
    end else begin
      unique case (opcode)
        OP_J:   strobes.isJumpImm = 1'b1;
        OP_JAL: begin
          strobes.isJumpImm = 1'b1;
          strobes.regWrite  = 1'b1;
          strobes.waSel     = WA_R31;
          strobes.wdSel     = WD_LINK;
        end
        OP_BEQ, OP_BNE: begin
          strobes.isBranch = 1'b1;
          strobes.brOnEq   = ~opcode[0];
          strobes.aluFn    = FN_SUB;
          strobes.sext     = 1'b1;
        end
        OP_LW: begin
          strobes.aluFn    = FN_ADD;
          strobes.sext     = 1'b1;
          strobes.bSel     = 1'b1;
          strobes.waSel    = WA_RT;
          strobes.wdSel    = WD_MEM;
          strobes.regWrite = 1'b1;
        end
        OP_SW: begin
          strobes.aluFn    = FN_ADD;
          strobes.sext     = 1'b1;
          strobes.bSel     = 1'b1;
          strobes.memWrite = 1'b1;
        end
        default: strobes.legal = 1'b0;
      endcase
    end
  end

  // R8: constant-16 A operand only for load upper
  always_comb begin
    if (strobes.legal && strobes.aSel == A_SIXTEEN)
      a_r8_sixteen_only_lui: assert (opcode == OP_LUI)
        else $error("a_r8_sixteen_only_lui");
  end

  // R9: memory read data is written back only by a load that adds
  always_comb begin
    if (strobes.legal && strobes.wdSel == WD_MEM)
      a_r9_memdata_from_load: assert (opcode == OP_LW && strobes.aluFn == FN_ADD && strobes.regWrite)
        else $error("a_r9_memdata_from_load");
  end

endmodule

// File: rtl/ctl_vector_drive.sv
module ctl_vector_drive
  import ctl_decoder_pkg::*;
(
  input  ctlStrobes_t         strobes,
  input  logic                aluZero,
  input  logic                rstSync,
  input  logic                irqSync,
  output logic [PCSEL_W-1:0]  pcSel,
  output logic                sextEn,
  output logic [SEL2_W-1:0]   waSel,
  output logic [SEL2_W-1:0]   wdSel,
  output logic [ALUFN_W-1:0]  aluFn,
  output logic                memWr,
  output logic                regWr,
  output logic [SEL2_W-1:0]   aSel,
  output logic                bSel
);

  logic branchTaken;
  assign branchTaken = strobes.isBranch && (aluZero == strobes.brOnEq);

  always_comb begin
    pcSel  = PC_SEQ;
    sextEn = strobes.sext;
    waSel  = strobes.waSel;
    wdSel  = strobes.wdSel;
    aluFn  = strobes.aluFn;
    memWr  = strobes.memWrite;
    regWr  = strobes.regWrite;
    aSel   = strobes.aSel;
    bSel   = strobes.bSel;
    if (rstSync || irqSync || !strobes.legal) begin
      sextEn = 1'b0;
      aluFn  = '0;
      memWr  = 1'b0;
      aSel   = A_RS;
      bSel   = 1'b0;
      wdSel  = WD_LINK;
      if (rstSync) begin
        pcSel = PC_RESET;
        waSel = WA_RD;
        regWr = 1'b0;
      end else begin
        pcSel = irqSync ? PC_IRQ : PC_ILLEGAL;
        waSel = WA_R27;
        regWr = 1'b1;
      end
    end else if (strobes.isJumpReg) begin
      pcSel = PC_JREG;
    end else if (strobes.isJumpImm) begin
      pcSel = PC_JIMM;
    end else if (branchTaken) begin
      pcSel = PC_BRANCH;
    end
  end

  always_comb begin
    if (rstSync)
      a_r1_reset_quiet: assert (pcSel == PC_RESET && !regWr && !memWr)
        else $error("a_r1_reset_quiet");
  end

  always_comb begin
    if (!rstSync && irqSync)
      a_r2_irq_links_r27: assert (pcSel == PC_IRQ && waSel == WA_R27 && wdSel == WD_LINK && regWr)
        else $error("a_r2_irq_links_r27");
  end

  always_comb begin
    if (pcSel == PC_ILLEGAL)
      a_r3_trap_only_unsupported: assert (!strobes.legal && waSel == WA_R27 && regWr && !memWr)
        else $error("a_r3_trap_only_unsupported");
  end

  always_comb begin
    a_r10_single_write: assert (!(memWr && regWr))
      else $error("a_r10_single_write");
  end

  always_comb begin
    if (pcSel == PC_BRANCH)
      a_r11_branch_condition: assert (strobes.isBranch && aluZero == strobes.brOnEq && !regWr)
        else $error("a_r11_branch_condition");
  end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_decoder_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       aluZero,
  input  logic       rstSync,
  input  logic       irqSync,
  output logic [2:0] pcSel,
  output logic       sextEn,
  output logic [1:0] waSel,
  output logic [1:0] wdSel,
  output logic [4:0] aluFn,
  output logic       memWr,
  output logic       regWr,
  output logic [1:0] aSel,
  output logic       bSel
);

  ctlStrobes_t strobes;

  ctl_op_decode u_decode (
    .opcode  (opcode),
    .funct   (funct),
    .strobes (strobes)
  );

  ctl_vector_drive u_drive (
    .strobes (strobes),
    .aluZero (aluZero),
    .rstSync (rstSync),
    .irqSync (irqSync),
    .pcSel   (pcSel),
    .sextEn  (sextEn),
    .waSel   (waSel),
    .wdSel   (wdSel),
    .aluFn   (aluFn),
    .memWr   (memWr),
    .regWr   (regWr),
    .aSel    (aSel),
    .bSel    (bSel)
  );

endmodule

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] opcode = '0;
  logic [5:0] funct  = '0;
  logic       aluZero = 1'b0;
  logic       rstSync = 1'b1;
  logic       irqSync = 1'b0;
  logic [2:0] pcSel;
  logic       sextEn;
  logic [1:0] waSel;
  logic [1:0] wdSel;
  logic [4:0] aluFn;
  logic       memWr;
  logic       regWr;
  logic [1:0] aSel;
  logic       bSel;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  ctl_decoder u_dut (
    .opcode(opcode), .funct(funct), .aluZero(aluZero),
    .rstSync(rstSync), .irqSync(irqSync),
    .pcSel(pcSel), .sextEn(sextEn), .waSel(waSel), .wdSel(wdSel),
    .aluFn(aluFn), .memWr(memWr), .regWr(regWr), .aSel(aSel), .bSel(bSel)
  );

  // {pcSel, sextEn, waSel, wdSel, aluFn, memWr, regWr, aSel, bSel}
  function automatic logic [18:0] pack(input logic [2:0] pc, input logic sx,
      input logic [1:0] wa, input logic [1:0] wd, input logic [4:0] fn,
      input logic mw, input logic rw, input logic [1:0] as, input logic bs);
    return {pc, sx, wa, wd, fn, mw, rw, as, bs};
  endfunction

  // reference built directly from the requirement text
  function automatic logic [18:0] model(input logic [5:0] op, input logic [5:0] fn,
      input logic z, input logic rst, input logic irq, output string tag);
    logic [18:0] trap;
    trap = pack(3'd5, 0, 2'd3, 2'd0, 5'b0, 0, 1, 2'd0, 0);
    tag = "R3";
    if (rst) begin tag = "R1"; return pack(3'd4, 0, 0, 0, 5'b0, 0, 0, 0, 0); end
    if (irq) begin tag = "R2"; return pack(3'd6, 0, 2'd3, 2'd0, 5'b0, 0, 1, 0, 0); end
    case (op)
      6'h00: case (fn)
        6'h20, 6'h21: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b00001, 0, 1, 0, 0); end
        6'h22, 6'h23: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b10001, 0, 1, 0, 0); end
        6'h24: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b00000, 0, 1, 0, 0); end
        6'h25: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b00100, 0, 1, 0, 0); end
        6'h26: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b01000, 0, 1, 0, 0); end
        6'h27: begin tag = "R4"; return pack(0, 0, 0, 1, 5'b01100, 0, 1, 0, 0); end
        6'h00: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b00010, 0, 1, 1, 0); end
        6'h02: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b01010, 0, 1, 1, 0); end
        6'h03: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b01110, 0, 1, 1, 0); end
        6'h04: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b00010, 0, 1, 0, 0); end
        6'h06: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b01010, 0, 1, 0, 0); end
        6'h07: begin tag = "R5"; return pack(0, 0, 0, 1, 5'b01110, 0, 1, 0, 0); end
        6'h2A: begin tag = "R6"; return pack(0, 0, 0, 1, 5'b10011, 0, 1, 0, 0); end
        6'h2B: begin tag = "R6"; return pack(0, 0, 0, 1, 5'b10111, 0, 1, 0, 0); end
        6'h08: begin tag = "R13"; return pack(3, 0, 0, 0, 5'b0, 0, 0, 0, 0); end
        6'h09: begin tag = "R13"; return pack(3, 0, 0, 0, 5'b0, 0, 1, 0, 0); end
        default: return trap;
      endcase
      6'h02: begin tag = "R12"; return pack(2, 0, 0, 0, 5'b0, 0, 0, 0, 0); end
      6'h03: begin tag = "R12"; return pack(2, 0, 2, 0, 5'b0, 0, 1, 0, 0); end
      6'h04: begin tag = "R11"; return pack(z ? 3'd1 : 3'd0, 1, 0, 0, 5'b10001, 0, 0, 0, 0); end
      6'h05: begin tag = "R11"; return pack(z ? 3'd0 : 3'd1, 1, 0, 0, 5'b10001, 0, 0, 0, 0); end
      6'h08, 6'h09: begin tag = "R7"; return pack(0, 1, 1, 1, 5'b00001, 0, 1, 0, 1); end
      6'h0A: begin tag = "R6"; return pack(0, 1, 1, 1, 5'b10011, 0, 1, 0, 1); end
      6'h0B: begin tag = "R6"; return pack(0, 1, 1, 1, 5'b10111, 0, 1, 0, 1); end
      6'h0C: begin tag = "R7"; return pack(0, 0, 1, 1, 5'b00000, 0, 1, 0, 1); end
      6'h0D: begin tag = "R7"; return pack(0, 0, 1, 1, 5'b00100, 0, 1, 0, 1); end
      6'h0E: begin tag = "R7"; return pack(0, 0, 1, 1, 5'b01000, 0, 1, 0, 1); end
      6'h0F: begin tag = "R8"; return pack(0, 0, 1, 1, 5'b00010, 0, 1, 2, 1); end
      6'h23: begin tag = "R9"; return pack(0, 1, 1, 2, 5'b00001, 0, 1, 0, 1); end
      6'h2B: begin tag = "R10"; return pack(0, 1, 0, 0, 5'b00001, 1, 0, 0, 1); end
      default: return trap;
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z,
      input logic rst, input logic irq, input string note);
    logic [18:0] exp;
    logic [18:0] act;
    string tag;
    @(negedge clk);
    opcode = op; funct = fn; aluZero = z; rstSync = rst; irqSync = irq;
    #1;
    exp = model(op, fn, z, rst, irq, tag);
    act = {pcSel, sextEn, waSel, wdSel, aluFn, memWr, regWr, aSel, bSel};
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s op=%b fn=%b z=%b rst=%b irq=%b actual=%b expected=%b",
               tag, note, op, fn, z, rst, irq, act, exp);
    end
  endtask

  initial begin
    // R1: reset state, even on a store that would write memory
    apply(6'h2B, 6'h00, 1'b0, 1'b1, 1'b0, "R1 reset over store");
    apply(6'h03, 6'h00, 1'b1, 1'b1, 1'b1, "R1 reset over irq and jal");
    // R2: interrupt beats an instruction and an illegal opcode
    apply(6'h23, 6'h00, 1'b0, 1'b0, 1'b1, "R2 irq over load");
    apply(6'h3F, 6'h3F, 1'b0, 1'b0, 1'b1, "R2 irq over illegal");
    // R3: multiply and undefined opcode trap
    apply(6'h00, 6'h18, 1'b0, 1'b0, 1'b0, "R3 multiply traps");
    apply(6'h01, 6'h00, 1'b0, 1'b0, 1'b0, "R3 undefined opcode");
    // R11: both branch outcomes
    apply(6'h04, 6'h00, 1'b1, 1'b0, 1'b0, "R11 beq taken");
    apply(6'h04, 6'h00, 1'b0, 1'b0, 1'b0, "R11 beq not taken");
    apply(6'h05, 6'h00, 1'b0, 1'b0, 1'b0, "R11 bne taken");
    apply(6'h05, 6'h00, 1'b1, 1'b0, 1'b0, "R11 bne not taken");
    // R8, R9, R10, R12, R13 directed
    apply(6'h0F, 6'h00, 1'b0, 1'b0, 1'b0, "R8 lui");
    apply(6'h23, 6'h00, 1'b0, 1'b0, 1'b0, "R9 load");
    apply(6'h2B, 6'h00, 1'b0, 1'b0, 1'b0, "R10 store");
    apply(6'h03, 6'h00, 1'b0, 1'b0, 1'b0, "R12 jal");
    apply(6'h00, 6'h09, 1'b0, 1'b0, 1'b0, "R13 jalr");
    apply(6'h00, 6'h01, 1'b0, 1'b0, 1'b0, "R5 gap in shift group traps");
    // full sweep: R4 R5 R6 R7 and everything above under all conditions
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        for (int c = 0; c < 8; c++)
          apply(op[5:0], fn[5:0], c[0], c[2], c[1], "sweep");
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule